// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only configuration port for a frequency synthesiser and its companion demodulator. A controller drives it over three wires: a serial clock, a serial data line and a load-enable line. The serial clock may run freely or stop between messages. Each message is 18 bits long. It carries a 16-bit payload followed by a 2-bit register address, and both fields are sent most significant bit first. A rising load-enable commits the message to the register that the address selects. The commit also emits a single-cycle strobe that restarts the divider chains fed by that register.

The three pins are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are detected on the synchronised copies. The port has two registers. The first holds the 16-bit feedback division ratio. The second holds the set-up word: a 5-bit reference-divider select and a flag that runs only the reference path, for demodulator-only operation. A message of the wrong length does not change any register. Instead it sets an error flag that stays set until reset.

Top module: `cfg_serial_port`

## Requirements
- R1: After a synchronous active-low reset, the ratio, reference select, demodulator-only flag, load strobe and framing error outputs are all zero.
- R2: Data is taken on each rising serial clock edge while load-enable is low, most significant bit first. Of the 18 bits received, the first 16 form the payload and the last 2 form the address.
- R3: Address 0 (bits 00) loads the full 16-bit payload into the ratio output.
- R4: Address 1 (bits 01) loads payload bits 4:0 into the reference select output and payload bit 5 into the demodulator-only flag. Payload bits 15:6 of this address have no effect.
- R5: Addresses 2 and 3 change no output and raise no load strobe.
- R6: Each accepted write to address 0 or 1 raises the load strobe for exactly one system cycle. The strobe is high in the same cycle in which the new register value first appears.
- R7: A message that does not contain exactly 18 bits when load-enable rises is discarded, and the framing error output is set. That output stays high until reset.
- R8: Every load-enable rise clears the bit count, so the next message is framed on its own, whatever went before.
- R9: Serial clock edges seen while the synchronised load-enable is high are ignored. This includes an edge that arrives in the same system cycle as the load-enable rise.
- R10: Register contents hold with the serial pins idle for any length of time.
- R11: A load-enable rise on the pin, stable across a system clock edge, updates the outputs on the third rising system clock edge after it.

Ports are listed in the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock pin, asynchronous |
| ser_dat_i | input | 1 | Serial data pin, asynchronous |
| ser_le_i | input | 1 | Load-enable pin, asynchronous |
| ratio_o | output | 16 | Feedback divider ratio |
| refsel_o | output | 5 | Reference divider select |
| demod_only_o | output | 1 | Run only the reference oscillator and divider |
| load_pulse_o | output | 1 | One-cycle divider restart strobe |
| frame_err_o | output | 1 | Sticky framing error |

## Verification
A serial clock edge and the load-enable rise can reach the logic in the same system cycle. That coincidence decides whether a stray extra clock turns a valid message into a framing error. The bench provokes it by sending a full 18-bit message, then raising the serial clock and load-enable together on one system cycle. The correct result is that the message commits, the strobe fires once, and the error flag stays low. A behavioural model keeps the delayed pin history in a queue and the received bits in a bit queue. Its outputs are compared with the design's on every system cycle, so the result is judged both by the final register value and by the timing of the strobe.

// File: rtl/cfgp_pkg.sv
// Shared constants and types for the serial configuration port.
// Assumes one fixed message layout: payload first, address last.
package cfgp_pkg;
    localparam int PAYLOAD_W = 16;
    localparam int ADDR_W    = 2;
    localparam int MSG_BITS  = PAYLOAD_W + ADDR_W;
    localparam int REFSEL_W  = 5;
    localparam int PIN_W     = 3;
    localparam int PIN_SCLK  = 0;
    localparam int PIN_SDAT  = 1;
    localparam int PIN_SLE   = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_RATIO  = 2'd0,
        ADDR_SETUP  = 2'd1,
        ADDR_SPARE2 = 2'd2,
        ADDR_SPARE3 = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/cfgp_sync.sv
// Multi-bit synchroniser: each bit has its own flop chain.
// Assumes the bits are unrelated pins; no cross-bit coherence is given.
module cfgp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the asynchronous pin through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/cfgp_framer.sv
// Serial framer: finds edges on the synchronised pins, shifts in data bits,
// counts them and reports a commit or a framing error on a load-enable rise.
// Assumes the inputs are already synchronous to clk.
module cfgp_framer #(
    parameter int PAYLOAD_W = cfgp_pkg::PAYLOAD_W,
    parameter int ADDR_W    = cfgp_pkg::ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_s,
    input  logic                 sdat_s,
    input  logic                 sle_s,
    output logic                 commit_o,
    output logic [PAYLOAD_W-1:0] payload_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic                 frame_err_o
);
    localparam int MSG_BITS = PAYLOAD_W + ADDR_W;
    localparam int CNT_W    = $clog2(MSG_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MSG_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(MSG_BITS + 1);

    logic                sclk_q, sle_q;
    logic                sclk_rise, le_rise;
    logic [MSG_BITS-1:0] shreg;
    logic [CNT_W-1:0]    cnt;

    // Remember last synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sle_q  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            sle_q  <= sle_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign le_rise   = sle_s & ~sle_q;

    // Shift data on serial clock rises; load-enable clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (le_rise) begin
            cnt <= '0;
        end else if (sclk_rise && !sle_s) begin
            shreg <= {shreg[MSG_BITS-2:0], sdat_s};
            if (cnt != CNT_OVER) cnt <= cnt + CNT_W'(1);
        end
    end

    // Sticky error for a message of the wrong length.
    always_ff @(posedge clk) begin
        if (!rst_n)                        frame_err_o <= 1'b0;
        else if (le_rise && cnt != CNT_FULL) frame_err_o <= 1'b1;
    end

    assign commit_o  = le_rise && (cnt == CNT_FULL);
    assign payload_o = shreg[MSG_BITS-1:ADDR_W];
    assign addr_o    = shreg[ADDR_W-1:0];

    AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise |=> (cnt == '0)); // R8
    AST_NO_SHIFT_LE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sle_s && !le_rise) |=> $stable(shreg)); // R9
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_OVER); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> frame_err_o); // R7
endmodule

// File: rtl/cfgp_regfile.sv
// Addressed register bank: stores ratio and set-up fields on a commit and
// raises a one-cycle restart strobe for writes to a defined address.
// Assumes commit is a single-cycle pulse.
module cfgp_regfile #(
    parameter int PAYLOAD_W = cfgp_pkg::PAYLOAD_W,
    parameter int ADDR_W    = cfgp_pkg::ADDR_W,
    parameter int REFSEL_W  = cfgp_pkg::REFSEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit_i,
    input  logic [PAYLOAD_W-1:0] payload_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [PAYLOAD_W-1:0] ratio_o,
    output logic [REFSEL_W-1:0]  refsel_o,
    output logic                 demod_only_o,
    output logic                 load_pulse_o
);
    import cfgp_pkg::*;

    // Decode the address and update the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_o      <= '0;
            refsel_o     <= '0;
            demod_only_o <= 1'b0;
            load_pulse_o <= 1'b0;
        end else begin
            load_pulse_o <= 1'b0;
            if (commit_i) begin
                case (addr_i)
                    ADDR_RATIO: begin
                        ratio_o      <= payload_i;
                        load_pulse_o <= 1'b1;
                    end
                    ADDR_SETUP: begin
                        refsel_o     <= payload_i[REFSEL_W-1:0];
                        demod_only_o <= payload_i[REFSEL_W];
                        load_pulse_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse_o |=> !load_pulse_o); // R6
    AST_RATIO_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_o) |-> load_pulse_o); // R3
    AST_SETUP_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({refsel_o, demod_only_o}) |-> load_pulse_o); // R4
    AST_SPARE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && addr_i[ADDR_W-1:1] != '0) |=> !load_pulse_o); // R5
endmodule

// File: rtl/cfg_serial_port.sv
// Top of the three-wire configuration port: synchronises the pins, frames
// 18-bit messages and writes the addressed register.
// Assumes pins hold each level for at least two system clock cycles.
module cfg_serial_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk_i,
    input  logic        ser_dat_i,
    input  logic        ser_le_i,
    output logic [15:0] ratio_o,
    output logic [4:0]  refsel_o,
    output logic        demod_only_o,
    output logic        load_pulse_o,
    output logic        frame_err_o
);
    import cfgp_pkg::*;

    logic [PIN_W-1:0]     pins_raw, pins_s;
    logic                 commit;
    logic [PAYLOAD_W-1:0] payload;
    logic [ADDR_W-1:0]    addr;

    assign pins_raw[PIN_SCLK] = ser_clk_i;
    assign pins_raw[PIN_SDAT] = ser_dat_i;
    assign pins_raw[PIN_SLE]  = ser_le_i;

    cfgp_sync #(.W(PIN_W), .STAGES(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    cfgp_framer #(.PAYLOAD_W(PAYLOAD_W), .ADDR_W(ADDR_W)) framer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (pins_s[PIN_SCLK]),
        .sdat_s      (pins_s[PIN_SDAT]),
        .sle_s       (pins_s[PIN_SLE]),
        .commit_o    (commit),
        .payload_o   (payload),
        .addr_o      (addr),
        .frame_err_o (frame_err_o)
    );

    cfgp_regfile #(.PAYLOAD_W(PAYLOAD_W), .ADDR_W(ADDR_W), .REFSEL_W(REFSEL_W)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit),
        .payload_i    (payload),
        .addr_i       (addr),
        .ratio_o      (ratio_o),
        .refsel_o     (refsel_o),
        .demod_only_o (demod_only_o),
        .load_pulse_o (load_pulse_o)
    );
endmodule

// File: tb/cfg_serial_port_tb_top.sv
module cfg_serial_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
    logic [15:0] ratio;
    logic [4:0]  refsel;
    logic        donly, load, ferr;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int exp_pulses = 0;

    always #5 clk = ~clk;

    cfg_serial_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
        .ratio_o(ratio), .refsel_o(refsel), .demod_only_o(donly),
        .load_pulse_o(load), .frame_err_o(ferr)
    );

    // Behavioural reference model: pin history queue plus received-bit queue.
    logic [2:0] hist[$];
    bit         mbits[$];
    logic [15:0] m_ratio;
    logic [4:0]  m_refsel;
    logic        m_donly, m_load, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{3'b000, 3'b000, 3'b000};
            mbits.delete();
            m_ratio = 0; m_refsel = 0; m_donly = 0; m_load = 0; m_err = 0;
        end else begin
            logic [2:0] cur, old;
            cur = hist[hist.size()-2];
            old = hist[hist.size()-3];
            m_load = 0;
            if (cur[2] && !old[2]) begin
                if (mbits.size() == 18) begin
                    int pl, ad;
                    pl = 0; ad = 0;
                    for (int i = 0; i < 16; i++) pl = pl * 2 + int'(mbits[i]);
                    ad = int'(mbits[16]) * 2 + int'(mbits[17]);
                    if (ad == 0) begin m_ratio = pl[15:0]; m_load = 1; end
                    if (ad == 1) begin m_refsel = pl[4:0]; m_donly = pl[5]; m_load = 1; end
                end else m_err = 1;
                mbits.delete();
            end else if (cur[0] && !old[0] && !cur[2]) begin
                if (mbits.size() < 19) mbits.push_back(cur[1]);
            end
            hist.push_back({sle, sdat, sclk});
            void'(hist.pop_front());
        end
    end

    always @(posedge clk) if (rst_n && load) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R11 timing, all outputs).
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R11 ratio cycle",  ratio,  m_ratio);
            chk("R11 refsel cycle", refsel, m_refsel);
            chk("R11 donly cycle",  donly,  m_donly);
            chk("R6 strobe cycle",  load,   m_load);
            chk("R7 err cycle",     ferr,   m_err);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdat = b; sclk = 1'b0; wait_n(3);
        sclk = 1'b1; wait_n(3);
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
        wait_n(3);
    endtask

    task automatic latch();
        sle = 1'b1; wait_n(4);
        sle = 1'b0; wait_n(4);
    endtask

    task automatic write(input logic [15:0] pl, input logic [1:0] ad);
        send_bits({14'b0, pl, ad}, 18);
        latch();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wait_n(4);
        rst_n = 1'b1; wait_n(2);
    endtask

    initial begin
        wait_n(3);
        chk("R1 ratio", ratio, 0); chk("R1 refsel", refsel, 0);
        chk("R1 donly", donly, 0); chk("R1 load", load, 0); chk("R1 err", ferr, 0);
        rst_n = 1'b1; wait_n(2);

        // R2 R3: ratio write, MSB first
        write(16'hA5C3, 2'b00); exp_pulses++;
        chk("R3 R2 ratio", ratio, 16'hA5C3); chk("R6 pulses", pulses, exp_pulses);

        // R4: set-up word
        write(16'h0035, 2'b01); exp_pulses++;
        chk("R4 refsel", refsel, 5'h15); chk("R4 donly", donly, 1);
        chk("R4 ratio kept", ratio, 16'hA5C3);
        write(16'hFFCA, 2'b01); exp_pulses++;
        chk("R4 high bits refsel", refsel, 5'h0A); chk("R4 high bits donly", donly, 0);
        chk("R6 pulses", pulses, exp_pulses);

        // R5: spare addresses
        write(16'h1234, 2'b10);
        write(16'h4321, 2'b11);
        chk("R5 ratio", ratio, 16'hA5C3); chk("R5 refsel", refsel, 5'h0A);
        chk("R5 donly", donly, 0); chk("R5 pulses", pulses, exp_pulses);

        // R7 R8: short message, then a clean one
        send_bits(32'h0_1FFFF, 17); latch();
        chk("R7 err short", ferr, 1); chk("R7 ratio kept", ratio, 16'hA5C3);
        write(16'h0FC0, 2'b00); exp_pulses++;
        chk("R8 ratio after error", ratio, 16'h0FC0); chk("R7 err sticky", ferr, 1);

        // R1 again, then R9 coincidence
        do_reset();
        chk("R1 ratio after reset", ratio, 0); chk("R1 err after reset", ferr, 0);
        send_bits({14'b0, 16'h1357, 2'b00}, 18);
        sclk = 1'b1; sle = 1'b1; wait_n(4);
        sclk = 1'b0; sle = 1'b0; wait_n(4);
        exp_pulses++;
        chk("R9 ratio coincident", ratio, 16'h1357); chk("R9 err low", ferr, 0);

        // R7: long message
        send_bits({13'b0, 1'b1, 16'h2222, 2'b00}, 19); latch();
        chk("R7 err long", ferr, 1); chk("R7 ratio kept long", ratio, 16'h1357);

        // R11: exact latency of the update and strobe
        send_bits({14'b0, 16'h00FF, 2'b00}, 18);
        sle = 1'b1;
        wait_n(1); chk("R11 not yet 1", ratio, 16'h1357);
        wait_n(1); chk("R11 not yet 2", ratio, 16'h1357); chk("R11 no strobe", load, 0);
        wait_n(1); chk("R11 updated", ratio, 16'h00FF); chk("R6 strobe high", load, 1);
        wait_n(1); chk("R6 strobe one cycle", load, 0);
        wait_n(2); sle = 1'b0; wait_n(4); exp_pulses++;

        // R10: long idle
        wait_n(3000);
        chk("R10 ratio held", ratio, 16'h00FF); chk("R10 refsel held", refsel, 0);
        chk("R6 pulses total", pulses, exp_pulses - 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule